// File: doc/BRIEF.md
# Second-Level Cache Hit Responder

This block sits in a system controller that shares a multiplexed address/data bus with a processor and an external level-2 cache. The processor manages the cache tags. A tag RAM reports a hit or a miss. The block watches for block reads. When a block read carries the cache-request flag, the block holds the cache data-RAM output enable high and waits. It samples the tag-match input exactly two cycles after the issue cycle. On a hit, it keeps the output enable high for the whole burst, stays off the bus and leaves the word index to the processor, so the cache RAM supplies the data.

On a miss, the block claims the read and drops the output enable. It then returns four beats through a response stub. For each beat it drives a 2-bit fill word index, so the cache data RAM captures the line as it streams past. The beats follow sub-block order: each beat index is the critical word XORed with a beat counter. A block read without the cache-request flag skips the lookup and is filled straight away. Only one read is tracked at a time.

Top module: `l2_hit_responder`

## Requirements
- R1: After reset the block is idle: `busy_o`, `dram_oe_o`, `bus_drive_o`, `word_drive_o` and `fetch_start_o` are 0, and `word_idx_o` and `bus_data_o` are 0.
- R2: An issue with both `blk_read_i` and `cache_req_i` high starts a lookup. For the two cycles after the issue edge, `dram_oe_o` and `busy_o` are 1, and `bus_drive_o` and `word_drive_o` are 0.
- R3: `match_i` is sampled only at the second clock edge after the issue edge. Its value at any other edge has no effect on the outcome.
- R4: On a hit (`match_i`=1 when sampled), `dram_oe_o` stays 1 for four more cycles. During those cycles `bus_drive_o` and `word_drive_o` stay 0. The block is idle in the cycle after.
- R5: On a miss, `dram_oe_o` is 0 and `bus_drive_o` is 1 for four cycles, starting right after the sampling edge. The block is idle in the cycle after.
- R6: During a fill, `word_idx_o` on beat b (b = 0..3) equals `crit_word_i` XOR b, where `crit_word_i` is the value captured at issue. For example, critical word 2 gives the sequence 2, 3, 0, 1.
- R7: `word_drive_o` is 1 exactly when `bus_drive_o` is 1. `bus_data_o` equals `fill_data_i` while driving and is 0 otherwise. `word_idx_o` is 0 outside a fill.
- R8: An issue with `blk_read_i`=1 and `cache_req_i`=0 skips the lookup. The four fill beats start in the cycle after the issue edge, and `dram_oe_o` stays 0 throughout.
- R9: An issue while `busy_o` is 1 is ignored. The current read runs to completion unchanged.
- R10: An issue with `blk_read_i`=0 is ignored, and the block stays idle.
- R11: `fetch_start_o` is a one-cycle pulse in the first beat of each fill. It is never high on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue cycle of a processor access |
| blk_read_i | input | 1 | The issued access is a block read |
| cache_req_i | input | 1 | Level-2 read request flag at issue |
| crit_word_i | input | IDX_W | Critical word index at issue |
| match_i | input | 1 | Tag-RAM match |
| fill_data_i | input | DATA_W | Beat data from the response stub, for the word on `word_idx_o` |
| busy_o | output | 1 | A read is being tracked |
| dram_oe_o | output | 1 | Cache data-RAM output enable (active high) |
| bus_drive_o | output | 1 | Block claims the read and drives data |
| bus_data_o | output | DATA_W | Beat data driven to the bus |
| word_drive_o | output | 1 | Block drives the fill word index |
| word_idx_o | output | IDX_W | Fill word index in sub-block order |
| fetch_start_o | output | 1 | First fill beat, start pulse to the response stub |

## Verification
The hardest case to reach is a stray match. Here `match_i` is high one cycle before or after the sampling edge, but low on that edge itself. Only an off-by-one in the lookup counter would turn such a case into a false hit. The vector table therefore carries an early/late match pattern: the bench raises `match_i` on the edges next to the sampling edge and sets the sampled value on its own. A second retire-time case is a fresh issue landing in the middle of a lookup. The bench injects one with a different critical word and checks that the fill order still follows the original.

// File: rtl/l2r_pkg.sv
package l2r_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_HIT    = 2'd2,
        ST_FILL   = 2'd3
    } l2r_state_e;
endpackage

// File: rtl/l2r_seq.sv
module l2r_seq
    import l2r_pkg::*;
#(
    parameter int MATCH_DLY = 2,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic             blk_read_i,
    input  logic             cache_req_i,
    input  logic [IDX_W-1:0] crit_i,
    input  logic             match_i,
    output l2r_state_e       state_o,
    output logic [IDX_W-1:0] beat_o,
    output logic [IDX_W-1:0] crit_o
);
    localparam int BEATS = 1 << IDX_W;
    localparam int CNT_W = $clog2(MATCH_DLY + BEATS) + 1;
    localparam logic [CNT_W-1:0] LOOK_LAST = CNT_W'(MATCH_DLY - 1);
    localparam logic [CNT_W-1:0] BEAT_LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        l2r_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] crit;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (issue_i && blk_read_i) begin
                    r_d.crit  = crit_i;
                    r_d.cnt   = '0;
                    r_d.state = cache_req_i ? ST_LOOKUP : ST_FILL;
                end
            end
            ST_LOOKUP: begin
                if (r_q.cnt == LOOK_LAST) begin
                    r_d.cnt   = '0;
                    r_d.state = match_i ? ST_HIT : ST_FILL;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HIT, ST_FILL: begin
                if (r_q.cnt == BEAT_LAST) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, crit: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign beat_o  = r_q.cnt[IDX_W-1:0];
    assign crit_o  = r_q.crit;

    // R9: a new issue while busy leaves the captured critical word alone
    a_r9_busy_keeps_crit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && issue_i) |=> $stable(r_q.crit));

    // R2: a lookup is only ever left after the full delay
    a_r2_lookup_length: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_LOOKUP && r_q.cnt != LOOK_LAST) |=> r_q.state == ST_LOOKUP);

    // R4: a hit is only entered out of a lookup
    a_r4_hit_from_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == ST_HIT) |-> $past(r_q.state) == ST_LOOKUP);
endmodule

// File: rtl/l2r_order.sv
module l2r_order #(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] crit_i,
    input  logic [IDX_W-1:0] beat_i,
    output logic [IDX_W-1:0] idx_o
);
    for (genvar g = 0; g < IDX_W; g++) begin : g_bit
        assign idx_o[g] = crit_i[g] ^ beat_i[g];
    end
endmodule

// File: rtl/l2_hit_responder.sv
module l2_hit_responder
    import l2r_pkg::*;
#(
    parameter int MATCH_DLY = 2,
    parameter int IDX_W     = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic              blk_read_i,
    input  logic              cache_req_i,
    input  logic [IDX_W-1:0]  crit_word_i,
    input  logic              match_i,
    input  logic [DATA_W-1:0] fill_data_i,
    output logic              busy_o,
    output logic              dram_oe_o,
    output logic              bus_drive_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              word_drive_o,
    output logic [IDX_W-1:0]  word_idx_o,
    output logic              fetch_start_o
);
    l2r_state_e       state;
    logic [IDX_W-1:0] beat;
    logic [IDX_W-1:0] crit;
    logic [IDX_W-1:0] order_idx;
    logic             filling;

    l2r_seq #(.MATCH_DLY(MATCH_DLY), .IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .blk_read_i (blk_read_i),
        .cache_req_i(cache_req_i),
        .crit_i     (crit_word_i),
        .match_i    (match_i),
        .state_o    (state),
        .beat_o     (beat),
        .crit_o     (crit)
    );

    l2r_order #(.IDX_W(IDX_W)) order_i (
        .crit_i(crit),
        .beat_i(beat),
        .idx_o (order_idx)
    );

    assign filling       = (state == ST_FILL);
    assign busy_o        = (state != ST_IDLE);
    assign dram_oe_o     = (state == ST_LOOKUP) || (state == ST_HIT);
    assign bus_drive_o   = filling;
    assign word_drive_o  = filling;
    assign word_idx_o    = filling ? order_idx : '0;
    assign bus_data_o    = filling ? fill_data_i : '0;
    assign fetch_start_o = filling && (beat == '0);

    // R5: the cache RAM never drives while this block claims the bus
    a_r5_oe_off_on_claim: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> !dram_oe_o);

    // R6: consecutive sub-block beats differ by XOR 1 or 3
    a_r6_subblock_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_drive_o && $past(word_drive_o) && !fetch_start_o) |->
        (((word_idx_o ^ $past(word_idx_o)) == IDX_W'(1)) ||
         ((word_idx_o ^ $past(word_idx_o)) == IDX_W'(3))));

    // R11: the start pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start_o |=> !fetch_start_o);

    // R7: index drive and data drive go together
    a_r7_drive_pair: assert property (@(posedge clk) disable iff (!rst_n)
        word_drive_o == bus_drive_o);

    // R10: a non-block issue from idle leaves the block idle
    a_r10_nonblock_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && issue_i && !blk_read_i) |=> !busy_o);
endmodule

// File: tb/l2_hit_responder_tb.sv
module l2_hit_responder_tb_top;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              issue_i, blk_read_i, cache_req_i, match_i;
    logic [IDX_W-1:0]  crit_word_i;
    logic [DATA_W-1:0] fill_data_i;
    logic              busy_o, dram_oe_o, bus_drive_o, word_drive_o, fetch_start_o;
    logic [DATA_W-1:0] bus_data_o;
    logic [IDX_W-1:0]  word_idx_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // response stub: data is a tag plus the requested word
    assign fill_data_i = {6'h2A, word_idx_o};

    l2_hit_responder dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .blk_read_i(blk_read_i),
        .cache_req_i(cache_req_i), .crit_word_i(crit_word_i), .match_i(match_i),
        .fill_data_i(fill_data_i), .busy_o(busy_o), .dram_oe_o(dram_oe_o),
        .bus_drive_o(bus_drive_o), .bus_data_o(bus_data_o), .word_drive_o(word_drive_o),
        .word_idx_o(word_idx_o), .fetch_start_o(fetch_start_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // packs busy, oe, drive, wdrive, fetch, idx, data for one comparison
    function automatic int pack(input logic b, input logic o, input logic d,
                                input logic w, input logic f, input logic [1:0] i,
                                input logic [7:0] dat);
        return {19'd0, b, o, d, w, f, i, dat};
    endfunction

    function automatic int observed();
        return pack(busy_o, dram_oe_o, bus_drive_o, word_drive_o, fetch_start_o,
                    word_idx_o, bus_data_o);
    endfunction

    // expected outputs k cycles after the issue edge
    function automatic int expect_at(input logic cache, input logic [1:0] crit,
                                     input logic hit, input int k);
        int fill_first;
        int b;
        logic [1:0] ix;
        fill_first = cache ? 3 : 1;
        if (cache && k <= 2) return pack(1, 1, 0, 0, 0, 0, 0);
        if (cache && hit) begin
            if (k <= 6) return pack(1, 1, 0, 0, 0, 0, 0);
            return pack(0, 0, 0, 0, 0, 0, 0);
        end
        b = k - fill_first;
        if (b > 3) return pack(0, 0, 0, 0, 0, 0, 0);
        ix = crit ^ 2'(b);
        return pack(1, 0, 1, 1, b == 0, ix, {6'h2A, ix});
    endfunction

    task automatic run_read(input string req, input logic cache, input logic [1:0] crit,
                            input logic hit, input logic stray, input logic poke);
        int last;
        last = cache ? 7 : 5;
        @(negedge clk);
        issue_i = 1; blk_read_i = 1; cache_req_i = cache; crit_word_i = crit;
        match_i = 0;
        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            check(req, observed(), expect_at(cache, crit, hit, k));
            issue_i = 0;
            match_i = (k == 2) ? hit : stray;
            if (poke && k == 2) begin
                issue_i = 1; cache_req_i = 0; crit_word_i = ~crit;
            end
        end
        match_i = 0; issue_i = 0;
    endtask

    // {cache, crit[1:0], hit, stray}
    localparam logic [4:0] VEC [8] = '{
        5'b1_00_1_0, 5'b1_01_0_0, 5'b1_10_0_1, 5'b1_11_1_1,
        5'b0_00_0_0, 5'b0_10_0_1, 5'b1_01_1_0, 5'b0_11_0_0
    };

    initial begin
        rst_n = 0; issue_i = 0; blk_read_i = 0; cache_req_i = 0;
        crit_word_i = 0; match_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset idle", observed(), pack(0, 0, 0, 0, 0, 0, 0));

        for (int v = 0; v < 8; v++) begin
            // R2 R3 R4 R5 R6 R7 R8 R11 per vector kind
            run_read(VEC[v][4] ? (VEC[v][1] ? "R4 hit" : "R5 R6 miss fill")
                               : "R8 direct fill",
                     VEC[v][4], VEC[v][3:2], VEC[v][1], VEC[v][0], 1'b0);
        end

        // R3: match high on neighbours, low on sampling edge -> miss
        run_read("R3 stray match", 1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
        // R9: a second issue mid-lookup is ignored
        run_read("R9 busy issue", 1'b1, 2'd1, 1'b0, 1'b0, 1'b1);
        run_read("R9 busy issue direct", 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);

        // R10: issue without block read
        @(negedge clk);
        issue_i = 1; blk_read_i = 0; cache_req_i = 1; crit_word_i = 2;
        @(negedge clk);
        issue_i = 0;
        check("R10 non-block ignored", observed(), pack(0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        check("R10 still idle", observed(), pack(0, 0, 0, 0, 0, 0, 0));

        // R1: reset in the middle of a fill returns to idle
        @(negedge clk);
        issue_i = 1; blk_read_i = 1; cache_req_i = 0; crit_word_i = 1;
        @(negedge clk);
        issue_i = 0;
        check("R8 fill started", int'(bus_drive_o), 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 reset mid fill", observed(), pack(0, 0, 0, 0, 0, 0, 0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule